// File: doc/BRIEF.md
# Interrupt Source Acceptance Unit

This unit sits at the point where one instruction has retired and the next has not yet started. It looks at every source that may redirect control flow and picks one. The sources are the exception flags reported by execution (division error, breakpoint, conditional and unconditional overflow check), the single-step trap flag, a non-maskable request pin and a maskable request line. For the chosen source it produces a vector number and a one-cycle valid strobe, which a downstream entry sequencer consumes.

Internal exceptions and single-step use fixed vectors. A non-maskable request also uses a fixed vector. A maskable request carries no vector of its own: the unit runs a short acknowledge handshake, and the requesting device answers by placing its vector on a data bus, which the unit latches. A restart flag goes out with each vector. It tells the sequencer whether the instruction at the boundary must be re-executed (fault) or not (trap).

Top module: `irq_accept_unit`

## Requirements
- R1: At a boundary, a division error gives vector 0, a breakpoint gives vector 3 and an overflow exception gives vector 4. If more than one of them is present, the lowest vector is the one raised.
- R2: The overflow exception is raised when the unconditional form is flagged. It is also raised when the conditional check is flagged while the overflow flag is 1. The conditional check with the overflow flag at 0 raises nothing.
- R3: `restart_o` is 1 together with a valid vector only for a division error. It is 0 for every other vector.
- R4: Among pending sources at one boundary, the order is: internal exception first, then single-step, then non-maskable, then maskable.
- R5: A boundary with the trap flag set, and no internal exception, raises vector 1. This holds at every such boundary, including consecutive ones.
- R6: A rising edge on `nmi_pin_i` leaves a request pending until a boundary takes it as vector 2. The request is accepted whatever the value of `int_en_i`. A pin held high gives one request only.
- R7: The maskable line is level-sensitive. It is recognised only when `int_en_i` is 1 at the boundary.
- R8: When a maskable request is taken at boundary edge T, `ack_o` is high for exactly one cycle after T. `bus_i` is sampled at edge T+2, and the sampled value is output with `vec_valid_o` high after T+2. `restart_o` is 0 for this vector.
- R9: A boundary that arrives while the acknowledge handshake is in progress is ignored. It raises no vector.
- R10: For a fixed-vector source, `vec_valid_o` is high for the one cycle after the boundary edge.
- R11: After reset, `vec_valid_o`, `ack_o`, `restart_o` and `vec_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary_i | input | 1 | Instruction boundary strobe; sources are evaluated in this cycle |
| div_err_i | input | 1 | Division error flagged by the finished instruction |
| brk_i | input | 1 | Breakpoint instruction executed |
| ovf_chk_i | input | 1 | Conditional overflow check executed |
| ovf_uncond_i | input | 1 | Unconditional overflow vector requested |
| ovf_flag_i | input | 1 | Current overflow flag |
| trap_flag_i | input | 1 | Single-step trap flag |
| int_en_i | input | 1 | Maskable interrupt enable flag |
| nmi_pin_i | input | 1 | Non-maskable request pin, edge-detected |
| intr_i | input | 1 | Maskable request line, level-sensitive |
| bus_i | input | VEC_W | Data bus on which the device returns its vector |
| ack_o | output | 1 | Acknowledge pulse to the requesting device |
| vec_valid_o | output | 1 | Vector strobe to the entry sequencer |
| vec_o | output | VEC_W | Vector number |
| restart_o | output | 1 | Instruction must be restarted (fault) |

## Verification
Two functions can meet in one cycle. The first is the choice between competing sources at a single boundary. The bench provokes this by sweeping all 512 combinations of the nine source and flag inputs, with a fresh non-maskable edge when the combination calls for one, and computes the winner arithmetically. The second is a new boundary that lands while a maskable acknowledge is in flight. The bench asserts a boundary with the trap flag during both the acknowledge and the capture cycle. It then judges that only the bus vector appears, and that a non-maskable request which lost arbitration is still delivered at a later, otherwise empty boundary.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

   typedef enum logic [1:0] {
      HS_IDLE = 2'd0,
      HS_ACK  = 2'd1,
      HS_CAPT = 2'd2
   } hs_state_e;

   typedef enum logic [2:0] {
      PICK_NONE = 3'd0,
      PICK_EXC  = 3'd1,
      PICK_STEP = 3'd2,
      PICK_NMI  = 3'd3,
      PICK_MASK = 3'd4
   } pick_e;

   localparam int unsigned VNUM_DIV  = 0;
   localparam int unsigned VNUM_STEP = 1;
   localparam int unsigned VNUM_NMI  = 2;
   localparam int unsigned VNUM_BRK  = 3;
   localparam int unsigned VNUM_OVF  = 4;

   localparam int unsigned EXC_SRC_N = 3;
   localparam int unsigned VNUM_MAX  = 4;

endpackage

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge #(
   parameter bit EDGE_MODE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic take_i,
   output logic pend_o
);

   generate
      if (EDGE_MODE) begin : g_edge
         logic prev_q;
         logic pend_q;
         logic rise;

         assign rise = pin_i & ~prev_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= 1'b0;
               pend_q <= 1'b0;
            end else begin
               prev_q <= pin_i;
               pend_q <= rise | (pend_q & ~take_i);
            end
         end

         assign pend_o = pend_q;

         // R6: a pending request survives until it is taken
         a_r6_nmi_held: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q && !take_i) |=> pend_q);
      end else begin : g_level
         assign pend_o = pin_i;
      end
   endgenerate

endmodule

// File: rtl/irq_exc_encode.sv
module irq_exc_encode
   import irq_accept_pkg::*;
#(
   parameter int unsigned VEC_W = 8
) (
   input  logic             div_err_i,
   input  logic             brk_i,
   input  logic             ovf_chk_i,
   input  logic             ovf_uncond_i,
   input  logic             ovf_flag_i,
   output logic             hit_o,
   output logic [VEC_W-1:0] vec_o,
   output logic             restart_o
);

   localparam int unsigned N = EXC_SRC_N;

   logic [N-1:0]       req;
   logic [VEC_W-1:0]   vtab [N];
   logic [N-1:0]       fault_tab;

   // index 0 is the highest priority
   assign req[0] = div_err_i;
   assign req[1] = brk_i;
   assign req[2] = ovf_uncond_i | (ovf_chk_i & ovf_flag_i);

   assign vtab[0] = VEC_W'(VNUM_DIV);
   assign vtab[1] = VEC_W'(VNUM_BRK);
   assign vtab[2] = VEC_W'(VNUM_OVF);

   assign fault_tab = N'(1);

   always_comb begin
      hit_o     = 1'b0;
      vec_o     = '0;
      restart_o = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            hit_o     = 1'b1;
            vec_o     = vtab[i];
            restart_o = fault_tab[i];
         end
      end
   end

endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
   import irq_accept_pkg::*;
#(
   parameter int unsigned VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [VEC_W-1:0] bus_i,
   output logic             ack_o,
   output logic             busy_o,
   output logic             cap_valid_o,
   output logic [VEC_W-1:0] cap_vec_o
);

   hs_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         HS_IDLE: if (start_i) state_d = HS_ACK;
         HS_ACK:  state_d = HS_CAPT;
         HS_CAPT: state_d = HS_IDLE;
         default: state_d = HS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= HS_IDLE;
      else        state_q <= state_d;
   end

   assign ack_o       = (state_q == HS_ACK);
   assign busy_o      = (state_q != HS_IDLE);
   assign cap_valid_o = (state_q == HS_CAPT);
   assign cap_vec_o   = bus_i;

   // R8: capture always follows the acknowledge cycle directly
   a_r8_ack_then_capt: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |=> (cap_valid_o && !ack_o));

endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
   import irq_accept_pkg::*;
#(
   parameter int unsigned VEC_W = 8
) (
   input  logic             exc_hit_i,
   input  logic [VEC_W-1:0] exc_vec_i,
   input  logic             exc_restart_i,
   input  logic             step_i,
   input  logic             nmi_i,
   input  logic             mask_i,
   output pick_e            pick_o,
   output logic [VEC_W-1:0] vec_o,
   output logic             restart_o
);

   always_comb begin
      pick_o    = PICK_NONE;
      vec_o     = '0;
      restart_o = 1'b0;
      if (exc_hit_i) begin
         pick_o    = PICK_EXC;
         vec_o     = exc_vec_i;
         restart_o = exc_restart_i;
      end else if (step_i) begin
         pick_o = PICK_STEP;
         vec_o  = VEC_W'(VNUM_STEP);
      end else if (nmi_i) begin
         pick_o = PICK_NMI;
         vec_o  = VEC_W'(VNUM_NMI);
      end else if (mask_i) begin
         pick_o = PICK_MASK;
      end
   end

endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
   import irq_accept_pkg::*;
#(
   parameter int unsigned VEC_W     = 8,
   parameter bit          NMI_EDGE  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             boundary_i,
   input  logic             div_err_i,
   input  logic             brk_i,
   input  logic             ovf_chk_i,
   input  logic             ovf_uncond_i,
   input  logic             ovf_flag_i,
   input  logic             trap_flag_i,
   input  logic             int_en_i,
   input  logic             nmi_pin_i,
   input  logic             intr_i,
   input  logic [VEC_W-1:0] bus_i,
   output logic             ack_o,
   output logic             vec_valid_o,
   output logic [VEC_W-1:0] vec_o,
   output logic             restart_o
);

   localparam int unsigned MIN_W = $clog2(VNUM_MAX + 1);

   generate
      if (VEC_W < MIN_W) begin : g_bad_width
         $error("VEC_W too narrow for the dedicated vectors");
      end
   endgenerate

   logic             exc_hit, exc_rst;
   logic [VEC_W-1:0] exc_vec;
   logic             nmi_pend, nmi_take;
   logic             hs_busy, cap_valid, hs_start;
   logic [VEC_W-1:0] cap_vec;
   logic             eval;
   pick_e            pick;
   logic [VEC_W-1:0] sel_vec;
   logic             sel_rst;

   logic             valid_q;
   logic [VEC_W-1:0] vec_q;
   logic             rst_q;

   assign eval = boundary_i & ~hs_busy;

   irq_exc_encode #(.VEC_W(VEC_W)) u_exc (
      .div_err_i    (div_err_i),
      .brk_i        (brk_i),
      .ovf_chk_i    (ovf_chk_i),
      .ovf_uncond_i (ovf_uncond_i),
      .ovf_flag_i   (ovf_flag_i),
      .hit_o        (exc_hit),
      .vec_o        (exc_vec),
      .restart_o    (exc_rst)
   );

   irq_nmi_edge #(.EDGE_MODE(NMI_EDGE)) u_nmi (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (nmi_pin_i),
      .take_i (nmi_take),
      .pend_o (nmi_pend)
   );

   irq_prio_select #(.VEC_W(VEC_W)) u_sel (
      .exc_hit_i     (exc_hit),
      .exc_vec_i     (exc_vec),
      .exc_restart_i (exc_rst),
      .step_i        (trap_flag_i),
      .nmi_i         (nmi_pend),
      .mask_i        (intr_i & int_en_i),
      .pick_o        (pick),
      .vec_o         (sel_vec),
      .restart_o     (sel_rst)
   );

   assign nmi_take = eval & (pick == PICK_NMI);
   assign hs_start = eval & (pick == PICK_MASK);

   irq_ack_fsm #(.VEC_W(VEC_W)) u_ack (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (hs_start),
      .bus_i       (bus_i),
      .ack_o       (ack_o),
      .busy_o      (hs_busy),
      .cap_valid_o (cap_valid),
      .cap_vec_o   (cap_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         vec_q   <= '0;
         rst_q   <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         rst_q   <= 1'b0;
         if (cap_valid) begin
            valid_q <= 1'b1;
            vec_q   <= cap_vec;
         end else if (eval && pick != PICK_NONE && pick != PICK_MASK) begin
            valid_q <= 1'b1;
            vec_q   <= sel_vec;
            rst_q   <= sel_rst;
         end
      end
   end

   assign vec_valid_o = valid_q;
   assign vec_o       = vec_q;
   assign restart_o   = rst_q;

   // R8: acknowledge lasts a single cycle
   a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |=> !ack_o);

   // R8: two edges after acknowledge the sampled bus value is presented
   a_r8_bus_capture: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> ##2 (vec_valid_o && (vec_o == $past(bus_i)) && !restart_o));

   // R7: acknowledge only starts from an enabled request at a boundary
   a_r7_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_o) |-> $past(int_en_i && intr_i && boundary_i));

   // R3: restart accompanies only the division vector
   a_r3_restart_div: assert property (@(posedge clk) disable iff (!rst_n)
      restart_o |-> (vec_valid_o && vec_o == '0));

   // R9: no direct vector appears in the cycle after acknowledge
   a_r9_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |=> !vec_valid_o);

endmodule

// File: tb/irq_accept_unit_tb_top.sv
module irq_accept_unit_tb_top;

   localparam int VW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic boundary_i = 0, div_err_i = 0, brk_i = 0, ovf_chk_i = 0;
   logic ovf_uncond_i = 0, ovf_flag_i = 0, trap_flag_i = 0, int_en_i = 0;
   logic nmi_pin_i = 0, intr_i = 0;
   logic [VW-1:0] bus_i = '0;
   logic ack_o, vec_valid_o, restart_o;
   logic [VW-1:0] vec_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   irq_accept_unit #(.VEC_W(VW), .NMI_EDGE(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i),
      .div_err_i(div_err_i), .brk_i(brk_i), .ovf_chk_i(ovf_chk_i),
      .ovf_uncond_i(ovf_uncond_i), .ovf_flag_i(ovf_flag_i),
      .trap_flag_i(trap_flag_i), .int_en_i(int_en_i),
      .nmi_pin_i(nmi_pin_i), .intr_i(intr_i), .bus_i(bus_i),
      .ack_o(ack_o), .vec_valid_o(vec_valid_o), .vec_o(vec_o),
      .restart_o(restart_o)
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clear_src();
      boundary_i = 0; div_err_i = 0; brk_i = 0; ovf_chk_i = 0;
      ovf_uncond_i = 0; ovf_flag_i = 0; trap_flag_i = 0; intr_i = 0;
   endtask

   task automatic expect_direct(input string req, input int v, input bit rs);
      chk({req, " valid"}, 32'(vec_valid_o), 1);
      chk({req, " vector"}, 32'(vec_o), 32'(v));
      chk({req, " restart"}, 32'(restart_o), 32'(rs));
      chk({req, " no ack"}, 32'(ack_o), 0);
   endtask

   task automatic expect_quiet(input string req);
      chk({req, " valid low"}, 32'(vec_valid_o), 0);
      chk({req, " ack low"}, 32'(ack_o), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      step(); step();
      // R11 reset state
      chk("R11 valid", 32'(vec_valid_o), 0);
      chk("R11 ack", 32'(ack_o), 0);
      chk("R11 vec", 32'(vec_o), 0);
      chk("R11 restart", 32'(restart_o), 0);
      rst_n = 1'b1;
      step(); step();
      expect_quiet("R11 idle after reset");

      // sweep: R1 R2 R3 R4 R5 R6 R7 R8 R10
      for (int c = 0; c < 512; c++) begin
         bit d, b, ck, un, fl, tr, nm, ir, ie, exc_h, take_nmi;
         int ev;
         logic [VW-1:0] val;
         d = c[0]; b = c[1]; ck = c[2]; un = c[3]; fl = c[4];
         tr = c[5]; nm = c[6]; ir = c[7]; ie = c[8];
         val = VW'(c * 37 + 11);
         exc_h = 1; ev = 0;
         if (d) ev = 0;
         else if (b) ev = 3;
         else if (un || (ck && fl)) ev = 4;
         else exc_h = 0;
         take_nmi = 0;
         if (nm) begin
            nmi_pin_i = 1; step(); nmi_pin_i = 0; step();
         end
         boundary_i = 1; div_err_i = d; brk_i = b; ovf_chk_i = ck;
         ovf_uncond_i = un; ovf_flag_i = fl; trap_flag_i = tr;
         intr_i = ir; int_en_i = ie;
         step();
         clear_src();
         if (exc_h) expect_direct("R1 R2 R3 R4 exception", ev, d);
         else if (tr) expect_direct("R4 R5 single-step", 1, 0);
         else if (nm) begin
            expect_direct("R4 R6 nmi", 2, 0);
            take_nmi = 1;
         end else if (ir && ie) begin
            chk("R7 R8 ack high", 32'(ack_o), 1);
            chk("R8 no valid during ack", 32'(vec_valid_o), 0);
            bus_i = ~val;
            step();
            chk("R8 ack one cycle", 32'(ack_o), 0);
            chk("R8 no valid in capture cycle", 32'(vec_valid_o), 0);
            bus_i = val;
            step();
            bus_i = ~val;
            chk("R8 valid", 32'(vec_valid_o), 1);
            chk("R8 bus vector", 32'(vec_o), 32'(val));
            chk("R8 restart low", 32'(restart_o), 0);
         end else expect_quiet("R2 R7 nothing raised");
         if (nm && !take_nmi) begin
            // R6 pending request delivered later
            boundary_i = 1; step(); boundary_i = 0;
            expect_direct("R6 nmi kept pending", 2, 0);
         end
         step();
         chk("R10 valid one cycle", 32'(vec_valid_o), 0);
      end

      // R6 held pin gives one request, ignoring enable
      int_en_i = 0;
      nmi_pin_i = 1; step(); step();
      boundary_i = 1; step(); boundary_i = 0;
      expect_direct("R6 held nmi first", 2, 0);
      step();
      boundary_i = 1; step(); boundary_i = 0;
      expect_quiet("R6 held nmi no repeat");
      nmi_pin_i = 0; step();

      // R5 consecutive trap boundaries
      boundary_i = 1; trap_flag_i = 1; step();
      expect_direct("R5 trap first", 1, 0);
      step();
      clear_src();
      expect_direct("R5 trap second", 1, 0);
      step();

      // R9 boundaries during handshake are ignored
      boundary_i = 1; intr_i = 1; int_en_i = 1; step();
      chk("R9 ack", 32'(ack_o), 1);
      intr_i = 0; bus_i = 8'h5A; trap_flag_i = 1; boundary_i = 1;
      step();
      chk("R9 ignored in ack cycle", 32'(vec_valid_o), 0);
      bus_i = 8'hC3;
      step();
      chk("R9 valid", 32'(vec_valid_o), 1);
      chk("R9 bus vector wins", 32'(vec_o), 32'h0C3);
      clear_src();
      step();
      expect_quiet("R9 ignored in capture cycle");

      // R7 level line held across two boundaries with enable
      boundary_i = 1; intr_i = 1; int_en_i = 1; step();
      boundary_i = 0; step(); bus_i = 8'h21; step();
      chk("R7 first level vector", 32'(vec_o), 32'h21);
      boundary_i = 1; step(); boundary_i = 0; intr_i = 0;
      chk("R7 level re-request ack", 32'(ack_o), 1);
      step(); bus_i = 8'h22; step();
      chk("R7 second level vector", 32'(vec_o), 32'h22);
      step();

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule